// File: doc/BRIEF.md
# Standby Wake-Up Sequencer

This block decides when a small controller leaves its software standby state and how its clocks come back. While running, a one-cycle entry request parks the block in software standby with the oscillator off and the clocks gated. A qualified interrupt edge (the non-maskable line or one of the IRQ lines) starts the oscillator and runs a programmable settling countdown. When the countdown ends, clocks are released and a one-cycle interrupt-start pulse is issued together with the latched wake cause.

An external reset pin takes a different path. Pulling it low starts the oscillator and releases the clocks in the same step, with no countdown. The reset-start pulse is held back until the pin goes high again. A hardware-off pin overrides everything and forces the block into hardware standby.

States: RUN, SW_STANDBY, SETTLING, RESET_HOLD, HW_STANDBY. The transitions are:
- RUN to SW_STANDBY on an entry request.
- SW_STANDBY to SETTLING on a qualified wake edge.
- SETTLING to RUN when the count expires.
- RUN, SW_STANDBY or SETTLING to RESET_HOLD while the reset pin is low.
- RESET_HOLD to RUN once the reset pin is high.
- Any state to HW_STANDBY while the hardware-off pin is low.
- HW_STANDBY to RESET_HOLD once that pin is high.

Top module: `standby_wake_seq`

## Requirements
- R1: After reset the block is in RUN: osc_en=1, clk_release=1, hw_off=0, irq_start=0, reset_start=0, wake_cause=0.
- R2: In RUN, standby_enter=1 at a clock edge moves the block to SW_STANDBY, where osc_en=0 and clk_release=0.
- R3: IRQ line n counts as a wake source only when irq_wake_en[n]=1, irq_en[n]=1, irq_cpu_mask[n]=0 and irq_dma_route[n]=0. Otherwise its edges leave the block in SW_STANDBY.
- R4: Wake inputs pass through a two-flop synchronizer and only rising edges count. An input first sampled high at edge k, after being low at edge k-1, moves the block to SETTLING at edge k+2. nmi_in is always a wake source.
- R5: SETTLING lasts exactly 2^(c+BASE_SHIFT) cycles with osc_en=1 and clk_release=0. Here c is settle_sel as sampled at the wake edge.
- R6: A settle_sel value above MAX_CODE is treated as MAX_CODE.
- R7: At the end of SETTLING the block enters RUN and irq_start is high for exactly one cycle. wake_cause equals NUM_IRQ (12) for nmi_in, or the IRQ index otherwise. When sources fire together, nmi_in wins, and among IRQ lines the lower index wins.
- R8: Wake edges in RUN or in SETTLING are ignored: no state change, no change of cause, no change of countdown.
- R9: ext_rst_n low in any state other than HW_STANDBY moves the block to RESET_HOLD at the next edge, with osc_en=1 and clk_release=1. This aborts any countdown.
- R10: reset_start is a one-cycle pulse issued only when ext_rst_n is high in RESET_HOLD, and the block then enters RUN. No pulse is issued on the falling edge of the pin.
- R11: hw_off_n low forces HW_STANDBY at the next edge from any state, taking priority over the reset pin. In HW_STANDBY hw_off=1, osc_en=0 and clk_release=0. When hw_off_n is high there, the block moves to RESET_HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| standby_enter | input | 1 | One-cycle request to enter software standby |
| nmi_in | input | 1 | Non-maskable wake input (asynchronous) |
| irq_in | input | NUM_IRQ | IRQ wake inputs (asynchronous) |
| irq_wake_en | input | NUM_IRQ | Per-line standby-clear enable |
| irq_en | input | NUM_IRQ | Per-line normal interrupt enable |
| irq_cpu_mask | input | NUM_IRQ | Line is masked on the processor side |
| irq_dma_route | input | NUM_IRQ | Line is routed to the transfer controller |
| settle_sel | input | CODE_W | Settling delay code |
| ext_rst_n | input | 1 | External reset pin, active low |
| hw_off_n | input | 1 | Hardware standby pin, active low |
| osc_en | output | 1 | Oscillator enable |
| clk_release | output | 1 | Clock gate release |
| hw_off | output | 1 | Hardware standby active |
| irq_start | output | 1 | One-cycle interrupt handling start |
| reset_start | output | 1 | One-cycle reset handling start |
| wake_cause | output | CAUSE_W | Latched wake source (NUM_IRQ for NMI) |

## Verification
The bench builds the block with BASE_SHIFT=2 and MAX_CODE=4, keeping NUM_IRQ=12. The settling window then spans 4 to 64 cycles, so every settle code including the clamped range 5 to 31 runs in full within a short test. All twelve IRQ lines stay present, so lowest-index priority and every gating qualifier can be exercised on real line positions. The aborted countdown can also be reached mid-window by both pins.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_SW_STBY   = 3'd1,
        ST_SETTLE    = 3'd2,
        ST_RST_HOLD  = 3'd3,
        ST_HW_STBY   = 3'd4
    } wake_state_t;

endpackage

// File: rtl/wake_edge_sync.sv
module wake_edge_sync #(
    parameter int WIDTH  = 13,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise
);
    // stages 0..STAGES-1 synchronize, the last one holds the previous value
    logic [WIDTH-1:0] pipe [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= async_in;
            for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/wake_select.sv
module wake_select #(
    parameter int NUM_IRQ = 12,
    parameter int CAUSE_W = $clog2(NUM_IRQ + 1)
) (
    input  logic               nmi_rise,
    input  logic [NUM_IRQ-1:0] irq_rise,
    input  logic [NUM_IRQ-1:0] irq_wake_en,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic [NUM_IRQ-1:0] irq_cpu_mask,
    input  logic [NUM_IRQ-1:0] irq_dma_route,
    output logic               wake_hit,
    output logic [CAUSE_W-1:0] wake_id
);
    logic [NUM_IRQ-1:0] qualified;

    always_comb begin
        qualified = irq_rise & irq_wake_en & irq_en & ~irq_cpu_mask & ~irq_dma_route;
        wake_hit  = nmi_rise | (|qualified);
        wake_id   = '0;
        if (nmi_rise) begin
            wake_id = CAUSE_W'(NUM_IRQ);
        end else begin
            // scan downward so the lowest set index is the one kept
            for (int i = NUM_IRQ - 1; i >= 0; i--) begin
                if (qualified[i]) wake_id = CAUSE_W'(i);
            end
        end
    end

endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int CODE_W     = 5,
    parameter int BASE_SHIFT = 6,
    parameter int MAX_CODE   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [CODE_W-1:0] settle_sel,
    output logic              done
);
    localparam int CNT_W = MAX_CODE + BASE_SHIFT + 1;
    localparam logic [CNT_W-1:0] MAX_LOAD = (CNT_W'(1) << (MAX_CODE + BASE_SHIFT)) - CNT_W'(1);

    logic [CODE_W-1:0] eff_code;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  cnt;

    always_comb begin
        eff_code = (32'(settle_sel) > MAX_CODE) ? CODE_W'(MAX_CODE) : settle_sel;
        load_val = (CNT_W'(1) << (32'(eff_code) + BASE_SHIFT)) - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (run && cnt != '0)  cnt <= cnt - CNT_W'(1);
    end

    assign done = (cnt == '0);

    // countdown never holds more than the clamped maximum window
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_LOAD);

endmodule

// File: rtl/standby_wake_seq.sv
module standby_wake_seq
    import wake_seq_pkg::*;
#(
    parameter int NUM_IRQ     = 12,
    parameter int CODE_W      = 5,
    parameter int BASE_SHIFT  = 6,
    parameter int MAX_CODE    = 15,
    parameter int SYNC_STAGES = 2,
    parameter int CAUSE_W     = $clog2(NUM_IRQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               standby_enter,
    input  logic               nmi_in,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] irq_wake_en,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic [NUM_IRQ-1:0] irq_cpu_mask,
    input  logic [NUM_IRQ-1:0] irq_dma_route,
    input  logic [CODE_W-1:0]  settle_sel,
    input  logic               ext_rst_n,
    input  logic               hw_off_n,
    output logic               osc_en,
    output logic               clk_release,
    output logic               hw_off,
    output logic               irq_start,
    output logic               reset_start,
    output logic [CAUSE_W-1:0] wake_cause
);
    localparam int SRC_W = NUM_IRQ + 1;

    wake_state_t        state, state_nx;
    logic [SRC_W-1:0]   src_rise;
    logic               wake_hit;
    logic [CAUSE_W-1:0] wake_id;
    logic               tmr_done;
    logic               tmr_load;
    logic               fire_irq, fire_rst;

    wake_edge_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({nmi_in, irq_in}),
        .rise     (src_rise)
    );

    wake_select #(.NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W)) u_select (
        .nmi_rise      (src_rise[NUM_IRQ]),
        .irq_rise      (src_rise[NUM_IRQ-1:0]),
        .irq_wake_en   (irq_wake_en),
        .irq_en        (irq_en),
        .irq_cpu_mask  (irq_cpu_mask),
        .irq_dma_route (irq_dma_route),
        .wake_hit      (wake_hit),
        .wake_id       (wake_id)
    );

    settle_timer #(.CODE_W(CODE_W), .BASE_SHIFT(BASE_SHIFT), .MAX_CODE(MAX_CODE)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .run        (state == ST_SETTLE),
        .settle_sel (settle_sel),
        .done       (tmr_done)
    );

    // next-state: hardware-off pin, then reset pin, then wake sources
    always_comb begin
        state_nx = state;
        fire_irq = 1'b0;
        fire_rst = 1'b0;
        if (!hw_off_n) begin
            state_nx = ST_HW_STBY;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (!ext_rst_n)         state_nx = ST_RST_HOLD;
                    else if (standby_enter) state_nx = ST_SW_STBY;
                end
                ST_SW_STBY: begin
                    if (!ext_rst_n)         state_nx = ST_RST_HOLD;
                    else if (wake_hit)      state_nx = ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (!ext_rst_n) begin
                        state_nx = ST_RST_HOLD;
                    end else if (tmr_done) begin
                        state_nx = ST_RUN;
                        fire_irq = 1'b1;
                    end
                end
                ST_RST_HOLD: begin
                    if (ext_rst_n) begin
                        state_nx = ST_RUN;
                        fire_rst = 1'b1;
                    end
                end
                ST_HW_STBY: state_nx = ST_RST_HOLD;
                default:    state_nx = ST_RUN;
            endcase
        end
    end

    assign tmr_load = (state == ST_SW_STBY) && (state_nx == ST_SETTLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_RUN;
            irq_start   <= 1'b0;
            reset_start <= 1'b0;
            wake_cause  <= '0;
        end else begin
            state       <= state_nx;
            irq_start   <= fire_irq;
            reset_start <= fire_rst;
            if (tmr_load) wake_cause <= wake_id;
        end
    end

    always_comb begin
        osc_en      = 1'b0;
        clk_release = 1'b0;
        hw_off      = 1'b0;
        unique case (state)
            ST_RUN:      begin osc_en = 1'b1; clk_release = 1'b1; end
            ST_SW_STBY:  ;
            ST_SETTLE:   osc_en = 1'b1;
            ST_RST_HOLD: begin osc_en = 1'b1; clk_release = 1'b1; end
            ST_HW_STBY:  hw_off = 1'b1;
            default:     ;
        endcase
    end

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |=> !irq_start);

    assert_irq_after_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |-> $past(state) == ST_SETTLE);

    assert_cause_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |=> $stable(wake_cause));

    assert_reset_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reset_start |-> ($past(ext_rst_n) && $past(state) == ST_RST_HOLD));

    assert_reset_clocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_off_n && !ext_rst_n && state != ST_HW_STBY) |=> (osc_en && clk_release));

    assert_hw_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_off_n |=> (hw_off && !osc_en && !clk_release));

endmodule

// File: tb/standby_wake_seq_test.sv
module standby_wake_seq_test;
    localparam int NIRQ  = 12;
    localparam int BASE  = 2;
    localparam int MAXC  = 4;
    localparam int CW    = 5;
    localparam int CAW   = 4;
    localparam int NMI_ID = NIRQ;

    localparam int M_RUN = 0, M_SW = 1, M_SE = 2, M_RH = 3, M_HW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic standby_enter = 1'b0;
    logic nmi_in = 1'b0;
    logic [NIRQ-1:0] irq_in = '0;
    logic [NIRQ-1:0] irq_wake_en = '1;
    logic [NIRQ-1:0] irq_en = '1;
    logic [NIRQ-1:0] irq_cpu_mask = '0;
    logic [NIRQ-1:0] irq_dma_route = '0;
    logic [CW-1:0]   settle_sel = '0;
    logic ext_rst_n = 1'b1;
    logic hw_off_n = 1'b1;
    logic osc_en, clk_release, hw_off, irq_start, reset_start;
    logic [CAW-1:0] wake_cause;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    standby_wake_seq #(.NUM_IRQ(NIRQ), .CODE_W(CW), .BASE_SHIFT(BASE), .MAX_CODE(MAXC)) uut (
        .clk(clk), .rst_n(rst_n), .standby_enter(standby_enter), .nmi_in(nmi_in),
        .irq_in(irq_in), .irq_wake_en(irq_wake_en), .irq_en(irq_en),
        .irq_cpu_mask(irq_cpu_mask), .irq_dma_route(irq_dma_route),
        .settle_sel(settle_sel), .ext_rst_n(ext_rst_n), .hw_off_n(hw_off_n),
        .osc_en(osc_en), .clk_release(clk_release), .hw_off(hw_off),
        .irq_start(irq_start), .reset_start(reset_start), .wake_cause(wake_cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int settle_len(input int code);
        int c;
        c = (code > MAXC) ? MAXC : code;
        return 1 << (c + BASE);
    endfunction

    // behavioural reference model
    int m_st = M_RUN;
    int m_left = 0;
    int m_cause = 0;
    bit m_irq = 0, m_rst = 0;
    logic [NIRQ:0] h1 = '0, h2 = '0, h3 = '0;

    always @(posedge clk) begin
        logic [NIRQ:0] rise;
        logic [NIRQ-1:0] qual;
        if (!rst_n) begin
            m_st = M_RUN; m_left = 0; m_cause = 0; m_irq = 0; m_rst = 0;
            h1 = '0; h2 = '0; h3 = '0;
        end else begin
            rise = h2 & ~h3;
            h3 = h2; h2 = h1; h1 = {nmi_in, irq_in};
            qual = rise[NIRQ-1:0] & irq_wake_en & irq_en & ~irq_cpu_mask & ~irq_dma_route;
            m_irq = 0; m_rst = 0;
            if (!hw_off_n) m_st = M_HW;
            else case (m_st)
                M_RUN: if (!ext_rst_n) m_st = M_RH; else if (standby_enter) m_st = M_SW;
                M_SW: begin
                    if (!ext_rst_n) m_st = M_RH;
                    else if (rise[NIRQ] || qual != 0) begin
                        m_st = M_SE;
                        m_left = settle_len(int'(settle_sel));
                        if (rise[NIRQ]) m_cause = NMI_ID;
                        else for (int i = NIRQ - 1; i >= 0; i--) if (qual[i]) m_cause = i;
                    end
                end
                M_SE: begin
                    if (!ext_rst_n) m_st = M_RH;
                    else begin
                        m_left--;
                        if (m_left == 0) begin m_st = M_RUN; m_irq = 1; end
                    end
                end
                M_RH: if (ext_rst_n) begin m_st = M_RUN; m_rst = 1; end
                default: m_st = M_RH;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 R5 osc_en model", int'(osc_en), int'(m_st == M_RUN || m_st == M_SE || m_st == M_RH));
            chk("R9 clk_release model", int'(clk_release), int'(m_st == M_RUN || m_st == M_RH));
            chk("R11 hw_off model", int'(hw_off), int'(m_st == M_HW));
            chk("R7 irq_start model", int'(irq_start), int'(m_irq));
            chk("R10 reset_start model", int'(reset_start), int'(m_rst));
            chk("R7 wake_cause model", int'(wake_cause), m_cause);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic enter_standby();
        standby_enter = 1'b1;
        cyc(1);
        standby_enter = 1'b0;
        cyc(1);
        chk("R2 osc off in standby", int'(osc_en), 0);
        chk("R2 clocks gated in standby", int'(clk_release), 0);
    endtask

    // wake on the given sources and measure the settling window
    task automatic do_wake(input string req, input int code, input logic [NIRQ:0] src,
                           input int exp_cause);
        int n;
        settle_sel = CW'(code);
        enter_standby();
        {nmi_in, irq_in} = src;
        n = 0;
        for (int i = 0; i < 400; i++) begin
            cyc(1);
            if (clk_release) break;
            if (osc_en) n++;
        end
        chk({req, " settling length"}, n, settle_len(code));
        chk({req, " irq_start on release"}, int'(irq_start), 1);
        chk({req, " wake_cause"}, int'(wake_cause), exp_cause);
        {nmi_in, irq_in} = '0;
        cyc(1);
        chk({req, " irq_start single"}, int'(irq_start), 0);
        cyc(3);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 osc_en", int'(osc_en), 1);
        chk("R1 clk_release", int'(clk_release), 1);
        chk("R1 hw_off", int'(hw_off), 0);
        chk("R1 pulses", int'(irq_start) + int'(reset_start), 0);
        chk("R1 wake_cause", int'(wake_cause), 0);

        do_wake("R4 nmi", 0, 13'h1000, NMI_ID);
        do_wake("R5 irq5", 2, 13'h0020, 5);
        do_wake("R6 code 9 clamped", 9, 13'h0001, 0);
        do_wake("R6 code 31 clamped", 31, 13'h0800, 11);
        do_wake("R7 nmi over irq3", 1, 13'h1008, NMI_ID);
        do_wake("R7 irq2 over irq7", 3, 13'h0084, 2);

        // R4: timing of the two-flop synchronizer
        settle_sel = CW'(4);
        enter_standby();
        irq_in[9] = 1'b1;      // first sampled at edge k
        cyc(2);                // edges k and k+1
        chk("R4 still standby after two edges", int'(osc_en), 0);
        cyc(1);                // edge k+2
        chk("R4 settling at edge k+2", int'(osc_en), 1);
        irq_in[9] = 1'b0;
        cyc(70);

        // R3: each qualifier blocks irq4
        enter_standby();
        for (int q = 0; q < 4; q++) begin
            irq_wake_en = '1; irq_en = '1; irq_cpu_mask = '0; irq_dma_route = '0;
            case (q)
                0: irq_wake_en[4] = 1'b0;
                1: irq_en[4] = 1'b0;
                2: irq_cpu_mask[4] = 1'b1;
                default: irq_dma_route[4] = 1'b1;
            endcase
            irq_in[4] = 1'b1;
            cyc(6);
            chk("R3 gated irq ignored osc", int'(osc_en), 0);
            chk("R3 gated irq ignored clk", int'(clk_release), 0);
            irq_in[4] = 1'b0;
            cyc(4);
        end
        irq_wake_en = '1; irq_en = '1; irq_cpu_mask = '0; irq_dma_route = '0;
        nmi_in = 1'b1; cyc(80); nmi_in = 1'b0; cyc(4);

        // R8: edge in RUN ignored
        irq_in[1] = 1'b1;
        cyc(6);
        chk("R8 run edge ignored", int'(clk_release), 1);
        irq_in[1] = 1'b0;
        cyc(3);

        // R8: edge during settling ignored
        settle_sel = CW'(3);
        enter_standby();
        irq_in[6] = 1'b1;
        cyc(10);
        nmi_in = 1'b1;
        for (int i = 0; i < 100; i++) begin
            cyc(1);
            if (clk_release) break;
        end
        chk("R8 cause kept through settling", int'(wake_cause), 6);
        irq_in[6] = 1'b0; nmi_in = 1'b0;
        cyc(4);

        // R9/R10: reset pin aborts countdown
        settle_sel = CW'(4);
        enter_standby();
        nmi_in = 1'b1;
        cyc(10);
        ext_rst_n = 1'b0;
        cyc(1);
        chk("R9 clocks released at once", int'(clk_release), 1);
        chk("R9 osc on at once", int'(osc_en), 1);
        chk("R10 no pulse on fall", int'(reset_start), 0);
        nmi_in = 1'b0;
        cyc(5);
        chk("R10 no pulse while held", int'(reset_start), 0);
        ext_rst_n = 1'b1;
        cyc(1);
        chk("R10 reset_start on release", int'(reset_start), 1);
        cyc(1);
        chk("R10 reset_start single", int'(reset_start), 0);
        chk("R9 no irq after abort", int'(irq_start), 0);
        cyc(3);

        // R11: hardware-off pin overrides reset pin during settling
        enter_standby();
        irq_in[0] = 1'b1;
        cyc(8);
        hw_off_n = 1'b0; ext_rst_n = 1'b0;
        cyc(1);
        chk("R11 hw_off asserted", int'(hw_off), 1);
        chk("R11 osc off", int'(osc_en), 0);
        irq_in[0] = 1'b0;
        cyc(4);
        hw_off_n = 1'b1;
        cyc(1);
        chk("R11 leaves to reset hold", int'(clk_release), 1);
        chk("R11 hw_off cleared", int'(hw_off), 0);
        ext_rst_n = 1'b1;
        cyc(1);
        chk("R11 reset_start after exit", int'(reset_start), 1);
        cyc(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule